// File: doc/BRIEF.md
# Priority-Threshold Normal Interrupt Selector

This block sits inside an interrupt controller core and resolves which of up to 64 normal (non-fast) interrupt sources should be presented to the processor. The core hands it a vector of sources that are already qualified: each one is pending, enabled and not routed to the fast path. The core also supplies a 4-bit priority for every source, packed eight to a 32-bit word, and a 5-bit threshold. The selector produces two results. One is an interrupt request bit, gated by a strict priority-above-threshold comparison. The other is the number and priority of the winning source, which the core places in its vector/status register.

The winner is the active source with the numerically largest priority. When several active sources share that priority, the highest-numbered one wins. A threshold of all ones turns the comparison off, so the request simply follows "any source active". When nothing is active, the selector flags that there is no winner, and the core turns this into its all-ones "nothing pending" code. Acknowledge and pending state stay in the core. The selector itself is a combinational resolver followed by an optional output register stage, which is enabled by default.

Top module: `prio_irq_selector`

## Requirements
- R1: The priority of source n is the 4-bit field at bits [4*(n mod 8)+3 : 4*(n mod 8)] of priority word n/8, and word k occupies bits [32*k+31 : 32*k] of the priority input bus.
- R2: When at least one source is active, win_id_o names the active source with the largest priority and win_prio_o carries that priority, whatever the source numbers are.
- R3: Among active sources that share the largest priority, the highest-numbered source wins.
- R4: When the threshold is 5'h1F, irq_o equals the OR of the active vector, with no priority test.
- R5: When the threshold is any value other than 5'h1F, irq_o is 1 only if some active source has a priority strictly greater than the threshold. Thresholds from 16 to 30 therefore never raise irq_o.
- R6: With no active source, valid_o, irq_o, win_id_o and win_prio_o are all 0.
- R7: A source with priority 0 can still be the vector winner, but it never raises irq_o unless the threshold is 5'h1F.
- R8: With the output stage enabled (default), the outputs show the inputs sampled at the previous rising clock edge, and a synchronous active-low reset clears all four outputs to 0.
- R9: Inactive sources have no effect on the outputs, whatever their priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| active_i | input | 64 | Qualified normal interrupt sources, bit n is source n |
| prio_words_i | input | 256 | Eight packed priority words, word k covers sources 8k to 8k+7 |
| mask_i | input | 5 | Priority threshold; 5'h1F bypasses the comparison |
| irq_o | output | 1 | Normal interrupt request |
| valid_o | output | 1 | At least one source active; winner fields are meaningful |
| win_id_o | output | 6 | Number of the winning source |
| win_prio_o | output | 4 | Priority of the winning source |

## Verification
The block holds no state apart from its output register, so a fault in the resolver shows up at the ports one clock after the inputs that expose it. A broken tree comparison or a reversed tie rule gives a wrong win_id_o on the first vector that has competing or equal priorities. A misplaced priority field gives the wrong winner when a single nibble is planted at a word boundary. An off-by-one in the threshold test flips irq_o when the threshold equals the best priority. A missed bypass shows up when the threshold is 5'h1F and only priority-0 sources are active. The bench uses vectors built to hit each of these cases and compares every output field at that one-cycle latency.

// File: rtl/sel_pkg.sv
// Package: shared defaults for the normal interrupt selector.
// Assumes the source count is a power of two so the selection tree is balanced.
package sel_pkg;
    localparam int DEF_NUM_SRC = 64;
    localparam int DEF_PRIO_W  = 4;
    localparam int DEF_MASK_W  = 5;
    localparam int DEF_WORD_W  = 32;

    // Threshold test: strict greater-than with zero extension of the priority.
    function automatic logic prio_above(input logic [7:0] prio, input logic [7:0] thr);
        return prio > thr;
    endfunction
endpackage

// File: rtl/prio_unpack.sv
// Module: prio_unpack
// Splits the packed priority words into one field per source.
// Assumes WORD_W is a multiple of PRIO_W and the words are concatenated with
// word 0 in the least significant position, so field n starts at bit PRIO_W*n.
module prio_unpack #(
    parameter int NUM_SRC = sel_pkg::DEF_NUM_SRC,
    parameter int PRIO_W  = sel_pkg::DEF_PRIO_W,
    parameter int WORD_W  = sel_pkg::DEF_WORD_W,
    localparam int PER_WORD = WORD_W / PRIO_W,
    localparam int N_WORDS  = NUM_SRC / PER_WORD
) (
    input  logic [N_WORDS*WORD_W-1:0] words_i,
    output logic [PRIO_W-1:0]         prio_o [NUM_SRC]
);
    // One slice per source: word n/PER_WORD, lane n mod PER_WORD.
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        localparam int WORD = n / PER_WORD;
        localparam int LANE = n % PER_WORD;
        assign prio_o[n] = words_i[WORD*WORD_W + LANE*PRIO_W +: PRIO_W];
    end
endmodule

// File: rtl/prio_tree.sv
// Module: prio_tree
// Balanced comparison tree that picks the active source with the largest
// priority. Ties go to the higher-numbered source. Nodes are laid out as a heap,
// so the left child always covers lower source numbers than the right child.
// Assumes NUM_SRC is a power of two.
module prio_tree #(
    parameter int NUM_SRC = sel_pkg::DEF_NUM_SRC,
    parameter int PRIO_W  = sel_pkg::DEF_PRIO_W,
    localparam int ID_W   = $clog2(NUM_SRC),
    localparam int NODES  = 2*NUM_SRC - 1
) (
    input  logic [NUM_SRC-1:0] active_i,
    input  logic [PRIO_W-1:0]  prio_i [NUM_SRC],
    output logic               valid_o,
    output logic [ID_W-1:0]    id_o,
    output logic [PRIO_W-1:0]  prio_o
);
    logic              nv [NODES];
    logic [ID_W-1:0]   nid [NODES];
    logic [PRIO_W-1:0] np [NODES];

    // Leaves: one per source, in ascending source order.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_leaf
        assign nv[NUM_SRC-1+i]  = active_i[i];
        assign nid[NUM_SRC-1+i] = ID_W'(i);
        assign np[NUM_SRC-1+i]  = prio_i[i];
    end

    // Inner nodes: the right (upper) child wins on equal priority.
    for (genvar i = 0; i < NUM_SRC-1; i++) begin : g_node
        logic take_r;
        assign take_r = nv[2*i+2] && (!nv[2*i+1] || (np[2*i+2] >= np[2*i+1]));
        assign nv[i]  = nv[2*i+1] | nv[2*i+2];
        assign nid[i] = take_r ? nid[2*i+2] : nid[2*i+1];
        assign np[i]  = take_r ? np[2*i+2]  : np[2*i+1];
    end

    // Root: winner fields are forced to zero when nothing is active.
    always_comb begin
        valid_o = nv[0];
        id_o    = nv[0] ? nid[0] : '0;
        prio_o  = nv[0] ? np[0]  : '0;
    end
endmodule

// File: rtl/thresh_gate.sv
// Module: thresh_gate
// Builds the request bit. Each active source is compared with the threshold on
// its own, and the per-source hits are ORed. An all-ones threshold disables
// the comparison. Assumes MASK_W > PRIO_W.
module thresh_gate #(
    parameter int NUM_SRC = sel_pkg::DEF_NUM_SRC,
    parameter int PRIO_W  = sel_pkg::DEF_PRIO_W,
    parameter int MASK_W  = sel_pkg::DEF_MASK_W
) (
    input  logic [NUM_SRC-1:0] active_i,
    input  logic [PRIO_W-1:0]  prio_i [NUM_SRC],
    input  logic [MASK_W-1:0]  mask_i,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] hit;
    logic               any_act;
    logic               bypass;

    // Per-source strict comparison against the threshold.
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_cmp
        assign hit[n] = active_i[n] &&
                        sel_pkg::prio_above(8'(prio_i[n]), 8'(mask_i));
    end

    // Combine: bypass or empty vector falls back to plain OR of sources.
    always_comb begin
        any_act = |active_i;
        bypass  = (mask_i == {MASK_W{1'b1}});
        irq_o   = (bypass || !any_act) ? any_act : |hit;
    end
endmodule

// File: rtl/prio_irq_selector.sv
// Module: prio_irq_selector (top)
// Resolves the normal interrupt request and the vector winner from qualified
// sources, packed priorities and a threshold. REG_OUT=1 adds one output
// register stage with synchronous active-low reset. REG_OUT=0 leaves the
// resolver combinational. Assumes inputs are already qualified by the core.
module prio_irq_selector #(
    parameter int NUM_SRC = sel_pkg::DEF_NUM_SRC,
    parameter int PRIO_W  = sel_pkg::DEF_PRIO_W,
    parameter int MASK_W  = sel_pkg::DEF_MASK_W,
    parameter int WORD_W  = sel_pkg::DEF_WORD_W,
    parameter bit REG_OUT = 1'b1,
    localparam int ID_W   = $clog2(NUM_SRC),
    localparam int BUS_W  = NUM_SRC * PRIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] active_i,
    input  logic [BUS_W-1:0]   prio_words_i,
    input  logic [MASK_W-1:0]  mask_i,
    output logic               irq_o,
    output logic               valid_o,
    output logic [ID_W-1:0]    win_id_o,
    output logic [PRIO_W-1:0]  win_prio_o
);
    logic [PRIO_W-1:0] prio_a [NUM_SRC];
    logic              c_irq, c_valid;
    logic [ID_W-1:0]   c_id;
    logic [PRIO_W-1:0] c_prio;

    prio_unpack #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .WORD_W(WORD_W)) u_unpack (
        .words_i (prio_words_i),
        .prio_o  (prio_a)
    );

    prio_tree #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_tree (
        .active_i (active_i),
        .prio_i   (prio_a),
        .valid_o  (c_valid),
        .id_o     (c_id),
        .prio_o   (c_prio)
    );

    thresh_gate #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W)) u_gate (
        .active_i (active_i),
        .prio_i   (prio_a),
        .mask_i   (mask_i),
        .irq_o    (c_irq)
    );

    if (REG_OUT) begin : g_reg
        // Output stage: capture resolver results, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq_o      <= 1'b0;
                valid_o    <= 1'b0;
                win_id_o   <= '0;
                win_prio_o <= '0;
            end else begin
                irq_o      <= c_irq;
                valid_o    <= c_valid;
                win_id_o   <= c_id;
                win_prio_o <= c_prio;
            end
        end
    end else begin : g_comb
        // Pass-through: resolver drives the ports directly.
        always_comb begin
            irq_o      = c_irq;
            valid_o    = c_valid;
            win_id_o   = c_id;
            win_prio_o = c_prio;
        end
    end
endmodule

// File: rtl/sel_checker.sv
// Module: sel_checker
// Port-level properties of the registered selector, bound to the top module.
// The sequential properties are only generated when REG_OUT is set.
module sel_checker #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int MASK_W  = 5,
    parameter bit REG_OUT = 1'b1,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] active_i,
    input logic [MASK_W-1:0]  mask_i,
    input logic               irq_o,
    input logic               valid_o,
    input logic [ID_W-1:0]    win_id_o,
    input logic [PRIO_W-1:0]  win_prio_o
);
    if (REG_OUT) begin : g_seq
        // R6/R8: valid follows any-active one clock later.
        a_r6_valid_tracks: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (valid_o == $past(|active_i)));
        // R4: bypass threshold makes the request a plain OR.
        a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_i == {MASK_W{1'b1}}) |=> (irq_o == $past(|active_i)));
        // R5: a request under a real threshold needs a winner above it.
        a_r5_strict: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o && ($past(mask_i) != {MASK_W{1'b1}})) |->
                (MASK_W'(win_prio_o) > $past(mask_i)));
        // R7: a priority-0 winner never requests unless bypassed.
        a_r7_zero_prio: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o && valid_o && (win_prio_o == '0)) |->
                ($past(mask_i) == {MASK_W{1'b1}}));
        // R9: the reported winner was active.
        a_r9_winner_active: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o |-> ((($past(active_i) >> win_id_o) & NUM_SRC'(1)) != '0));
    end

    // R6: with no winner, every other output is zero.
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (!irq_o && (win_id_o == '0) && (win_prio_o == '0)));
endmodule

bind prio_irq_selector sel_checker #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W), .REG_OUT(REG_OUT)
) u_sel_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (active_i),
    .mask_i     (mask_i),
    .irq_o      (irq_o),
    .valid_o    (valid_o),
    .win_id_o   (win_id_o),
    .win_prio_o (win_prio_o)
);

// File: tb/prio_irq_selector_bench.sv
// Bench: table-driven vectors followed by directed reset, latency and
// field-position tests. Outputs are sampled at the falling edge.
module prio_irq_selector_bench;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [63:0]  active_i;
    logic [255:0] prio_words_i;
    logic [4:0]   mask_i;
    logic         irq_o, valid_o;
    logic [5:0]   win_id_o;
    logic [3:0]   win_prio_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    prio_irq_selector u_prio_irq_selector (
        .clk(clk), .rst_n(rst_n), .active_i(active_i), .prio_words_i(prio_words_i),
        .mask_i(mask_i), .irq_o(irq_o), .valid_o(valid_o),
        .win_id_o(win_id_o), .win_prio_o(win_prio_o)
    );

    typedef struct packed {
        logic [63:0] act;
        logic [4:0]  mask;
        logic [1:0]  mode;   // 0: all prio 0, 1: prio n mod 16, 2: all prio 5
        logic        irq;
        logic        vld;
        logic [5:0]  id;
        logic [3:0]  pr;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{64'h0, 5'd0, 2'd1, 1'b0, 1'b0, 6'd0, 4'd0},                               // R6
        '{64'h0000_0000_0000_0408, 5'd0, 2'd1, 1'b1, 1'b1, 6'd10, 4'd10},           // R2
        '{64'h0000_0020_0020_0020, 5'd4, 2'd2, 1'b1, 1'b1, 6'd37, 4'd5},            // R3
        '{64'h0000_0020_0020_0020, 5'd5, 2'd2, 1'b0, 1'b1, 6'd37, 4'd5},            // R5
        '{64'h0000_0000_0000_0001, 5'h1F, 2'd0, 1'b1, 1'b1, 6'd0, 4'd0},            // R4
        '{64'h8000_0000_0000_0000, 5'd0, 2'd0, 1'b0, 1'b1, 6'd63, 4'd0},            // R7
        '{64'hFFFF_FFFF_FFFF_FFFF, 5'd16, 2'd1, 1'b0, 1'b1, 6'd63, 4'd15},          // R5
        '{64'hFFFF_FFFF_FFFF_FFFF, 5'd14, 2'd1, 1'b1, 1'b1, 6'd63, 4'd15},          // R3
        '{64'h4000_0000_0000_8000, 5'd14, 2'd1, 1'b1, 1'b1, 6'd15, 4'd15},          // R2
        '{64'h0000_0000_0000_0180, 5'd0, 2'd1, 1'b1, 1'b1, 6'd8, 4'd8},             // R1
        '{64'h0000_0000_0000_0004, 5'd1, 2'd1, 1'b1, 1'b1, 6'd2, 4'd2}              // R9
    };

    // Builds the priority bus for a pattern, using the R1 field placement.
    function automatic logic [255:0] mk_prio(input logic [1:0] mode);
        logic [255:0] w = '0;
        for (int n = 0; n < 64; n++) begin
            logic [3:0] p;
            p = (mode == 2'd1) ? 4'(n % 16) : (mode == 2'd2) ? 4'd5 : 4'd0;
            w[32*(n/8) + 4*(n%8) +: 4] = p;
        end
        return w;
    endfunction

    task automatic check(input string req, input logic e_irq, input logic e_vld,
                         input logic [5:0] e_id, input logic [3:0] e_pr);
        n_chk++;
        if (irq_o !== e_irq || valid_o !== e_vld || win_id_o !== e_id || win_prio_o !== e_pr) begin
            n_fail++;
            $display("FAIL %s: got irq=%0b valid=%0b id=%0d prio=%0d, expected irq=%0b valid=%0b id=%0d prio=%0d",
                     req, irq_o, valid_o, win_id_o, win_prio_o, e_irq, e_vld, e_id, e_pr);
        end
    endtask

    // Drive at the falling edge, let one rising edge capture, sample at the next falling edge.
    task automatic apply(input logic [63:0] a, input logic [255:0] p, input logic [4:0] m);
        active_i = a; prio_words_i = p; mask_i = m;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        active_i = '1; prio_words_i = mk_prio(2'd1); mask_i = 5'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset clears outputs", 1'b0, 1'b0, 6'd0, 4'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].act, mk_prio(VECS[i].mode), VECS[i].mask);
            check($sformatf("vector %0d", i), VECS[i].irq, VECS[i].vld, VECS[i].id, VECS[i].pr);
        end

        // R8: new inputs are not visible before the next rising edge.
        active_i = 64'h0000_0000_0000_0004; prio_words_i = mk_prio(2'd1); mask_i = 5'd1;
        @(negedge clk);
        active_i = 64'h0; #1;
        check("R8 output held until edge", 1'b1, 1'b1, 6'd2, 4'd2);
        @(posedge clk); @(negedge clk);
        check("R8 update after edge", 1'b0, 1'b0, 6'd0, 4'd0);

        // R1: a single nibble set to 9 in field n decides the winner.
        foreach (VECS[0].id[k]) begin end
        for (int t = 0; t < 4; t++) begin
            int n;
            logic [255:0] w;
            n = (t == 0) ? 0 : (t == 1) ? 13 : (t == 2) ? 42 : 63;
            w = '0;
            w[32*(n/8) + 4*(n%8) +: 4] = 4'd9;
            apply('1, w, 5'd8);
            check($sformatf("R1 field of source %0d", n), 1'b1, 1'b1, 6'(n), 4'd9);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule